// File: doc/BRIEF.md
# HDLC Transmit Framer with Inter-Frame Spacing

This block turns frames written one byte at a time into a serial HDLC line signal. Bytes are held in a 64-byte store together with an end-of-frame marker. A bit engine advances once for every cycle in which the transmit clock enable is high. When the line is idle it sends the flag pattern continuously. When a frame is allowed to start, it sends the content least significant bit first, inserts a zero after every run of five ones, and appends a frame check sequence of 16 or 32 bits. It then closes the frame with a flag.

A frame is held back until enough bytes are stored. Either the fill level must reach a programmable watermark, or a whole frame must already be in the store. Successive frames are separated by a programmable number of flags. If the store runs dry before the end-of-frame byte is reached, the engine aborts the frame with a run of ones, raises a one-cycle underrun pulse and goes back to sending flags.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `tx_bit` is 1. While no frame is being sent, the line carries back-to-back 8-bit flags 01111110 with no other bits between them.
- R2: Inside frame content and the check sequence, a 0 is inserted after every five consecutive 1 bits. This includes the bytes 0xFF and 0x7E.
- R3: Each data byte goes out least significant bit first, and `tx_bit` changes only in cycles where `tx_ce` is high. The content between flags, with stuffing removed, is the written bytes in order, followed by the check sequence.
- R4: When `cfg_fcs32` is 0, the check sequence is 16 bits. It uses x^16+x^12+x^5+1 (reflected constant 0x8408), is preset to all ones, is computed over the content bytes, and is sent complemented, low byte first, each byte LSB first.
- R5: When `cfg_fcs32` is 1, the check sequence is the standard 32-bit one (reflected constant 0xEDB88320). It is preset to all ones and sent complemented, LSB first. `cfg_fcs32` is sampled when a frame starts.
- R6: When the next frame is already stored, exactly G flags separate the last check bit from the next frame's first content bit. A single flag both closes one frame and opens the next. G is `cfg_gap`, clamped to 1..62, so 0 acts as 1 and 63 acts as 62.
- R7: A frame starts only when the stored byte count is at least `cfg_wmark`, or when a byte marked as end-of-frame is stored.
- R8: The store holds 64 bytes. `wr_full` is 1 at 64 stored bytes, and a write while `wr_full` is 1 is discarded.
- R9: If the store is empty at a byte boundary inside a frame, the engine sends 8 ones (an abort) and `tx_underrun` pulses high for one clock as the first abort bit appears.
- R10: After an abort, the line returns to flags and the next stored frame is sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Marks the written byte as the end of its frame |
| wr_full | output | 1 | Store holds 64 bytes; writes are dropped |
| cfg_fcs32 | input | 1 | 1 selects the 32-bit check sequence, 0 the 16-bit one |
| cfg_gap | input | 6 | Flags between frames (clamped to 1..62) |
| cfg_wmark | input | 7 | Hold-off watermark in stored bytes |
| tx_ce | input | 1 | Transmit clock enable, one line bit per high cycle |
| tx_bit | output | 1 | Serial line output, registered |
| tx_underrun | output | 1 | One-cycle pulse when an abort begins |

## Verification
The assertions assume three things about the inputs. The configuration inputs are held steady while a frame is in flight. The writer never counts on a write landing while `wr_full` is high. Underruns come only from the writer stalling in the middle of a frame. The stimulus changes configuration only after every expected frame has been seen on the line. It pulses `tx_ce` every other clock, so byte writes at one per clock stay ahead of the line unless the bench withholds the end-of-frame byte on purpose. A receiver model in the bench removes stuffing, counts flags and compares each frame against the bytes and check sequence the driver queued.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
  localparam logic [15:0] POLY16_REFL  = 16'h8408;
  localparam logic [31:0] POLY32_REFL  = 32'hEDB88320;
  localparam int unsigned STUFF_RUN    = 5;

  // One reflected CRC step; in 16-bit mode only the low half moves.
  function automatic logic [31:0] crc_step(input logic [31:0] c,
                                           input logic d,
                                           input logic wide);
    logic        fb;
    logic [15:0] c16;
    logic [31:0] c32;
    fb = c[0] ^ d;
    if (wide) begin
      c32 = {1'b0, c[31:1]};
      if (fb) c32 = c32 ^ POLY32_REFL;
      return c32;
    end else begin
      c16 = {1'b0, c[15:1]};
      if (fb) c16 = c16 ^ POLY16_REFL;
      return {c[31:16], c16};
    end
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_last,
  output logic             full,
  input  logic             pop,
  output logic             head_v,
  output logic [DW-1:0]    head_data,
  output logic             head_last,
  output logic [LVL_W-1:0] level,
  output logic             frame_held
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DW:0]      mem [DEPTH];
  logic [DW:0]      head_q;
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] mem_cnt, lvl_q, frames_q;
  logic             head_vq;
  logic             push, fetch, deq;

  assign full  = (lvl_q >= LVL_W'(DEPTH));
  assign push  = wr_en && !full;
  assign deq   = pop && head_vq;
  assign fetch = (mem_cnt != '0) && (!head_vq || pop);

  // storage array with synchronous read, suited to block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (fetch) head_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      mem_cnt  <= '0;
      lvl_q    <= '0;
      frames_q <= '0;
      head_vq  <= 1'b0;
    end else begin
      if (push)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (fetch) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, fetch})
        2'b10:   mem_cnt <= mem_cnt + 1'b1;
        2'b01:   mem_cnt <= mem_cnt - 1'b1;
        default: mem_cnt <= mem_cnt;
      endcase
      case ({push, deq})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
      case ({push && wr_last, deq && head_q[DW]})
        2'b10:   frames_q <= frames_q + 1'b1;
        2'b01:   frames_q <= frames_q - 1'b1;
        default: frames_q <= frames_q;
      endcase
      if (fetch)    head_vq <= 1'b1;
      else if (deq) head_vq <= 1'b0;
    end
  end

  assign head_v     = head_vq;
  assign head_data  = head_q[DW-1:0];
  assign head_last  = head_q[DW];
  assign level      = lvl_q;
  assign frame_held = (frames_q != '0);
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
#(
  parameter int CRC_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic upd,
  input  logic din,
  input  logic shift,
  input  logic wide,
  output logic fcs_bit
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init)  crc_q <= '1;
    else if (upd)     crc_q <= crc_step(crc_q, din, wide);
    else if (shift)   crc_q <= {1'b0, crc_q[CRC_W-1:1]};
  end

  // the check sequence leaves complemented, low bit first
  assign fcs_bit = ~crc_q[0];
endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
#(
  parameter int LVL_W   = 7,
  parameter int GAP_W   = 6,
  parameter int MAX_GAP = 62,
  localparam int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_ce,
  input  logic             head_v,
  input  logic [7:0]       head_data,
  input  logic             head_last,
  input  logic [LVL_W-1:0] level,
  input  logic             frame_held,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [LVL_W-1:0] cfg_wmark,
  input  logic             cfg_fcs32,
  input  logic             fcs_bit,
  output logic             pop,
  output logic             crc_init,
  output logic             crc_upd,
  output logic             crc_din,
  output logic             crc_shift,
  output logic             crc_wide,
  output logic             tx_bit,
  output logic             underrun
);
  timeunit 1ns;
  timeprecision 1ps;

  tx_state_e        st_q, st_n;
  logic [7:0]       sh_q, sh_n;
  logic             last_q, last_n;
  logic [2:0]       idx_q, idx_n;
  logic [2:0]       ones_q, ones_n;
  logic [GAP_W-1:0] fcnt_q, fcnt_n, fc_inc, gap_eff;
  logic [CNT_W-1:0] fsent_q, fsent_n, fcs_len;
  logic             wide_q, wide_n;
  logic             bit_q, bit_n;
  logic             urun_n, urun_q;
  logic             may_start;

  always_comb begin
    if (cfg_gap == '0)                     gap_eff = GAP_W'(1);
    else if (cfg_gap > GAP_W'(MAX_GAP))    gap_eff = GAP_W'(MAX_GAP);
    else                                   gap_eff = cfg_gap;
  end

  assign fc_inc    = (fcnt_q == '1) ? fcnt_q : fcnt_q + 1'b1;
  assign fcs_len   = wide_q ? CNT_W'(32) : CNT_W'(16);
  assign may_start = head_v && ((level >= cfg_wmark) || frame_held) &&
                     (fc_inc >= gap_eff);
  assign crc_wide  = wide_q;

  always_comb begin
    st_n      = st_q;
    sh_n      = sh_q;
    last_n    = last_q;
    idx_n     = idx_q;
    ones_n    = ones_q;
    fcnt_n    = fcnt_q;
    fsent_n   = fsent_q;
    wide_n    = wide_q;
    bit_n     = bit_q;
    urun_n    = 1'b0;
    pop       = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_din   = 1'b0;
    crc_shift = 1'b0;
    if (tx_ce) begin
      unique case (st_q)
        ST_FLAG: begin
          bit_n = FLAG_PATTERN[idx_q];
          idx_n = idx_q + 1'b1;
          if (idx_q == 3'd7) begin
            fcnt_n = fc_inc;
            if (may_start) begin
              st_n     = ST_DATA;
              sh_n     = head_data;
              last_n   = head_last;
              pop      = 1'b1;
              crc_init = 1'b1;
              wide_n   = cfg_fcs32;
              ones_n   = '0;
            end
          end
        end
        ST_DATA: begin
          if (ones_q == 3'(STUFF_RUN)) begin
            bit_n  = 1'b0;
            ones_n = '0;
          end else begin
            bit_n   = sh_q[0];
            crc_upd = 1'b1;
            crc_din = sh_q[0];
            ones_n  = sh_q[0] ? ones_q + 1'b1 : '0;
            sh_n    = {1'b0, sh_q[7:1]};
            idx_n   = idx_q + 1'b1;
            if (idx_q == 3'd7) begin
              if (last_q) begin
                st_n    = ST_FCS;
                fsent_n = '0;
              end else if (head_v) begin
                sh_n   = head_data;
                last_n = head_last;
                pop    = 1'b1;
              end else begin
                st_n = ST_ABORT;
              end
            end
          end
        end
        ST_FCS: begin
          if (ones_q == 3'(STUFF_RUN)) begin
            bit_n  = 1'b0;
            ones_n = '0;
          end else if (fsent_q == fcs_len) begin
            // closing flag: its first bit leaves now
            bit_n  = FLAG_PATTERN[0];
            st_n   = ST_FLAG;
            idx_n  = 3'd1;
            fcnt_n = '0;
            ones_n = '0;
          end else begin
            bit_n     = fcs_bit;
            crc_shift = 1'b1;
            ones_n    = fcs_bit ? ones_q + 1'b1 : '0;
            fsent_n   = fsent_q + 1'b1;
          end
        end
        ST_ABORT: begin
          bit_n  = 1'b1;
          urun_n = (idx_q == 3'd0);
          idx_n  = idx_q + 1'b1;
          if (idx_q == 3'd7) begin
            st_n   = ST_FLAG;
            idx_n  = '0;
            fcnt_n = '0;
            ones_n = '0;
          end
        end
        default: st_n = ST_FLAG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_FLAG;
      sh_q    <= '0;
      last_q  <= 1'b0;
      idx_q   <= '0;
      ones_q  <= '0;
      fcnt_q  <= '1;
      fsent_q <= '0;
      wide_q  <= 1'b0;
      bit_q   <= 1'b1;
      urun_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      sh_q    <= sh_n;
      last_q  <= last_n;
      idx_q   <= idx_n;
      ones_q  <= ones_n;
      fcnt_q  <= fcnt_n;
      fsent_q <= fsent_n;
      wide_q  <= wide_n;
      bit_q   <= bit_n;
      urun_q  <= urun_n;
    end
  end

  assign tx_bit   = bit_q;
  assign underrun = urun_q;
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int DEPTH   = 64,
  parameter int GAP_W   = 6,
  parameter int MAX_GAP = 62,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  output logic             wr_full,
  input  logic             cfg_fcs32,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [LVL_W-1:0] cfg_wmark,
  input  logic             tx_ce,
  output logic             tx_bit,
  output logic             tx_underrun
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             pop, head_v, head_last, frame_held;
  logic [7:0]       head_data;
  logic [LVL_W-1:0] fifo_level;
  logic             crc_init, crc_upd, crc_din, crc_shift, crc_wide, fcs_bit;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .full(wr_full),
    .pop(pop), .head_v(head_v), .head_data(head_data), .head_last(head_last),
    .level(fifo_level), .frame_held(frame_held)
  );

  hdlc_tx_serial #(.LVL_W(LVL_W), .GAP_W(GAP_W), .MAX_GAP(MAX_GAP)) u_ser (
    .clk(clk), .rst(rst), .tx_ce(tx_ce),
    .head_v(head_v), .head_data(head_data), .head_last(head_last),
    .level(fifo_level), .frame_held(frame_held),
    .cfg_gap(cfg_gap), .cfg_wmark(cfg_wmark), .cfg_fcs32(cfg_fcs32),
    .fcs_bit(fcs_bit), .pop(pop),
    .crc_init(crc_init), .crc_upd(crc_upd), .crc_din(crc_din),
    .crc_shift(crc_shift), .crc_wide(crc_wide),
    .tx_bit(tx_bit), .underrun(tx_underrun)
  );

  hdlc_tx_fcs #(.CRC_W(32)) u_fcs (
    .clk(clk), .rst(rst), .init(crc_init), .upd(crc_upd), .din(crc_din),
    .shift(crc_shift), .wide(crc_wide), .fcs_bit(fcs_bit)
  );
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_ce,
  input logic             tx_bit,
  input logic             tx_underrun,
  input logic             wr_en,
  input logic             wr_full,
  input logic [LVL_W-1:0] level
);
  timeunit 1ns;
  timeprecision 1ps;

  p_bit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tx_ce |=> $stable(tx_bit));

  p_urun_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> !tx_underrun);

  p_urun_mark_r9: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> tx_bit);

  p_no_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_full) |=> (level <= $past(level)));

  p_level_bound_r8: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));
endmodule

bind hdlc_tx_framer hdlc_tx_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .tx_ce(tx_ce), .tx_bit(tx_bit),
  .tx_underrun(tx_underrun), .wr_en(wr_en), .wr_full(wr_full),
  .level(fifo_level)
);

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_last = 1'b0, cfg_fcs32 = 1'b0, tx_ce = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] cfg_gap = 6'd1;
  logic [6:0] cfg_wmark = '0;
  logic       wr_full, tx_bit, tx_underrun;

  int total = 0, bad = 0;
  bit ce_on = 1'b0, ce_q = 1'b0, done = 1'b0;

  // expected frames: bytes incl. check sequence; length -1 marks an abort
  logic [7:0] exp_bytes[$];
  int         exp_len[$];
  int         exp_gap[$];
  string      exp_tag[$];
  logic [7:0] frm[$];

  // receiver model state
  bit rxq[$];
  bit hunt = 1'b1, urun_seen = 1'b0;
  int ones = 0, flag_cnt = 0, stuffed = 0, frames_rx = 0, maxq = 0;

  hdlc_tx_framer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .wr_full(wr_full), .cfg_fcs32(cfg_fcs32), .cfg_gap(cfg_gap),
    .cfg_wmark(cfg_wmark), .tx_ce(tx_ce), .tx_bit(tx_bit),
    .tx_underrun(tx_underrun)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // transmit clock enable: every other clock while enabled
  initial forever begin
    @(negedge clk);
    tx_ce = ce_on ? ~tx_ce : 1'b0;
  end

  always @(posedge clk) ce_q <= tx_ce;

  task automatic end_frame();
    int n, L, g, nb;
    string t;
    logic [7:0] b;
    logic [7:0] e;
    n = rxq.size() - 7;
    if (exp_len.size() == 0) begin
      chk(0, "R3", "unexpected frame bits", n, 0);
      return;
    end
    L = exp_len.pop_front(); g = exp_gap.pop_front(); t = exp_tag.pop_front();
    if (L < 0) begin
      chk(0, "R9", "frame seen where abort expected", n / 8, -1);
      return;
    end
    chk(n % 8 == 0, t, "frame not byte aligned, bits", n, L * 8);
    nb = n / 8;
    chk(nb == L, t, "frame length", nb, L);
    for (int i = 0; i < L; i++) begin
      e = exp_bytes.pop_front();
      b = '0;
      if (i < nb) for (int k = 0; k < 8; k++) b[k] = rxq[i * 8 + k];
      if (b != e) chk(0, t, $sformatf("byte %0d", i), b, e);
    end
    total++;
    if (g >= 0) chk(flag_cnt == g, "R6", "flags between frames", flag_cnt, g);
    frames_rx++;
  endtask

  task automatic rx_bit(input bit b);
    if (b) begin
      ones++;
      if (!hunt) rxq.push_back(1'b1);
      if (ones == 7 && !hunt) begin
        hunt = 1'b1;
        rxq.delete();
        if (exp_len.size() == 0) chk(0, "R9", "unexpected abort", 1, 0);
        else begin
          chk(exp_len[0] == -1, "R9", "abort where frame expected", -1, exp_len[0]);
          if (exp_len[0] > 0) repeat (exp_len[0]) void'(exp_bytes.pop_front());
          void'(exp_len.pop_front()); void'(exp_gap.pop_front());
          void'(exp_tag.pop_front());
        end
        chk(urun_seen, "R9", "underrun pulse at abort", urun_seen, 1);
        urun_seen = 1'b0;
      end
    end else begin
      if (ones == 6) begin
        if (hunt) begin
          hunt = 1'b0;
          flag_cnt = 1;
        end else if (rxq.size() == 7) begin
          flag_cnt++;
        end else begin
          end_frame();
          flag_cnt = 1;
        end
        rxq.delete();
      end else if (ones == 5) begin
        if (!hunt) stuffed++;
      end else if (!hunt) begin
        rxq.push_back(1'b0);
      end
      ones = 0;
    end
    if (rxq.size() > maxq) maxq = rxq.size();
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_underrun) urun_seen = 1'b1;
      if (ce_q) rx_bit(tx_bit);
    end
  end

  task automatic build(input int n, input int seed, input bit ones_only);
    frm.delete();
    for (int i = 0; i < n; i++)
      if (ones_only) frm.push_back(8'hFF);
      else if (i == 1) frm.push_back(8'h7E);
      else frm.push_back(8'((seed * 29 + i * 53 + 7) & 255));
  endtask

  task automatic expect_frame(input bit wide, input int gap, input string tag);
    logic [31:0] c;
    logic        fb;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    foreach (frm[i]) begin
      exp_bytes.push_back(frm[i]);
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ frm[i][k];
        c = c >> 1;
        if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
      end
    end
    c = ~c;
    for (int k = 0; k < (wide ? 4 : 2); k++) exp_bytes.push_back(c[k*8 +: 8]);
    exp_len.push_back(frm.size() + (wide ? 4 : 2));
    exp_gap.push_back(gap);
    exp_tag.push_back(tag);
  endtask

  task automatic write_range(input int lo, input int hi, input bit mark_end);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = frm[i]; wr_last = mark_end && (i == hi - 1);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic send(input int n, input int seed, input bit ff, input int gap,
                      input string tag);
    build(n, seed, ff);
    expect_frame(cfg_fcs32, gap, tag);
    write_range(0, n, 1'b1);
  endtask

  task automatic drain();
    while (exp_len.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int s0, f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_bit == 1'b1, "R1", "tx_bit after reset", tx_bit, 1);
    chk(tx_underrun == 1'b0, "R9", "underrun after reset", tx_underrun, 0);
    chk(wr_full == 1'b0, "R8", "full after reset", wr_full, 0);
    ce_on = 1'b1;
    repeat (200) @(negedge clk);
    chk(!hunt && flag_cnt >= 5, "R1", "idle flags counted", flag_cnt, 5);

    // R3 R4 R6: two back-to-back 16-bit frames, gap 3
    cfg_gap = 6'd3;
    send(6, 1, 0, -1, "R4");
    send(5, 2, 0, 3, "R3");
    drain();

    // R2: all-ones content forces stuffing
    s0 = stuffed;
    send(4, 0, 1, -1, "R2");
    drain();
    chk(stuffed - s0 >= 6, "R2", "stuffed zeros removed", stuffed - s0, 6);

    // R5 R6: 32-bit sequence, gap 1 shares the flag
    cfg_fcs32 = 1'b1; cfg_gap = 6'd1;
    send(7, 3, 0, -1, "R5");
    send(3, 4, 0, 1, "R5");
    drain();
    cfg_fcs32 = 1'b0;

    // R6: clamping of gap 0 and 63
    cfg_gap = 6'd0;
    send(2, 5, 0, -1, "R6");
    send(2, 6, 0, 1, "R6");
    drain();
    cfg_gap = 6'd63;
    send(3, 7, 0, -1, "R6");
    send(2, 8, 0, 62, "R6");
    drain();
    cfg_gap = 6'd2;

    // R7: held off below the watermark
    cfg_wmark = 7'd12;
    build(14, 9, 0);
    expect_frame(1'b0, -1, "R7");
    write_range(0, 5, 1'b0);
    maxq = 0;
    repeat (400) @(negedge clk);
    chk(maxq <= 7, "R7", "content bits sent below watermark", maxq, 7);
    write_range(5, 14, 1'b1);
    drain();
    // R7: a complete short frame goes out below the watermark
    cfg_wmark = 7'd40;
    send(3, 10, 0, -1, "R7");
    drain();
    cfg_wmark = 7'd0;

    // R8: fill the store with the line stopped
    ce_on = 1'b0;
    repeat (20) @(negedge clk);
    build(64, 11, 0);
    expect_frame(1'b0, -1, "R8");
    write_range(0, 64, 1'b1);
    chk(wr_full == 1'b1, "R8", "full at 64 bytes", wr_full, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hAA; wr_last = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
    chk(wr_full == 1'b1, "R8", "full after dropped write", wr_full, 1);
    f0 = frames_rx;
    ce_on = 1'b1;
    drain();
    repeat (600) @(negedge clk);
    chk(frames_rx == f0 + 1, "R8", "frames after full test", frames_rx, f0 + 1);
    chk(wr_full == 1'b0, "R8", "full after drain", wr_full, 0);

    // R9: underrun aborts a frame with no end marker
    cfg_wmark = 7'd2;
    build(3, 12, 0);
    exp_len.push_back(-1); exp_gap.push_back(-1); exp_tag.push_back("R9");
    write_range(0, 3, 1'b0);
    drain();

    // R10: normal frame after the abort
    cfg_wmark = 7'd0;
    send(4, 13, 0, -1, "R10");
    drain();
    chk(exp_len.size() == 0, "R10", "expected frames left", exp_len.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule